// File: doc/BRIEF.md
# Coprocessor-to-Host Bus Cycle Bridge

This block lets software on an 8-bit host service the bus cycles of a 16-bit coprocessor. When the coprocessor reads or writes an address that lies in one of the host-serviced address windows, the bridge captures the address, the direction and, for a write, the data word. It then holds the coprocessor in wait states. Host software inspects the cycle through eight byte-wide registers. For a read it supplies the data word. It then either completes the cycle or throws it away with a bus error. An access outside every window fails with a bus error at once, and the host is not involved.

The host side is a plain byte port with one-cycle read and write strobes and a 3-bit offset. Read data is registered and appears the cycle after the read strobe. The coprocessor side is a request level. The coprocessor holds `cp_req` with stable address, lanes and data until it sees a one-cycle `cp_ready` or `cp_berr` pulse, and then drops `cp_req`.

The cycle controller has five states. ST_IDLE waits for a request. It takes the *accept* transition to ST_WAIT for a forwarded address, or the *reject* transition to ST_FAULT for any other address. ST_WAIT holds the stall. It takes the *ack* transition to ST_DONE on an acknowledge write made while the reset bit is clear, or the *abort* transition to ST_FAULT on a write to offset 3. ST_DONE and ST_FAULT each last one cycle and take the *finish* transition to ST_DRAIN. ST_DRAIN takes the *release* transition back to ST_IDLE once `cp_req` is low.

Top module: `cp_host_bridge`

## Requirements
- R1: A request is forwarded only if its byte address falls inside one of these ranges: 0x200000–0x2FFFFF, 0x420000–0x42FFFF, 0x510000–0x51FFFF, 0x520000–0x52FFFF, 0x538000–0x53FFFF, 0x5F2000–0x5F3FFF, 0x690000–0x69FFFF, 0x6F0000–0x6FFFFF, 0x730000–0x73FFFF or 0x7A0000–0x7AFFFF. For any other address `cp_berr` is high in the cycle after the request is first sampled.
- R2: A forwarded request produces neither `cp_ready` nor `cp_berr` until the host acts on it.
- R3: While a cycle is pending, host reads at offsets 2, 3 and 4 return bits 7:0, 15:8 and 23:16 of the captured address. The captured address is the request address plus one when `cp_lanes` is 2'b01 (low lane only), and the request address otherwise.
- R4: Offsets 0 and 1 hold the low and high bytes of the data word. A forwarded write loads the word from `cp_wdata`, and host writes replace single bytes. On a completed read, `cp_rdata` carries the word in the same cycle as `cp_ready`.
- R5: A host write to offset 7 during a pending cycle raises `cp_ready` for exactly one cycle, beginning the cycle after the write. No new request is accepted until `cp_req` has been low.
- R6: While the reset bit is 1, a host write to offset 7 is ignored, and the cycle stays pending.
- R7: A host write to offset 3 during a pending cycle ends that cycle with a one-cycle `cp_berr`. When no cycle is pending, such a write has no effect.
- R8: Bit 0 of a host write to offset 2 is stored and driven on `cp_reset` from the next cycle on.
- R9: The status byte read at offset 7 is built from a base value ORed with two flags. The base is 0xE4 when idle. During a pending cycle the base comes from the captured address: 0x30 for 0x200000–0x2FFFFF, 0x70 for 0x512000–0x517FFF, 0x50 for 0x51FF00–0x51FFFF, 0xB0 for 0x538000–0x53FFFF, and 0xD0 for any other address. Bit 2 is ORed in for a pending read. Bit 4 is ORed in when `host_irq` is low.
- R10: When no cycle is pending, each host read at offsets 2–4 first inverts all 24 bits of the held address, then returns the selected byte of the inverted value.
- R11: After reset the held address and data are zero, no cycle is pending, `cp_reset` is 0 and both completion pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_req | input | 1 | Coprocessor access request, held until completion |
| cp_we | input | 1 | 1 = write, 0 = read |
| cp_addr | input | 24 | Coprocessor byte address |
| cp_lanes | input | 2 | Byte lane enables, bit 1 high byte, bit 0 low byte |
| cp_wdata | input | 16 | Coprocessor write data |
| cp_rdata | output | 16 | Data word returned to the coprocessor |
| cp_ready | output | 1 | One-cycle cycle-complete pulse |
| cp_berr | output | 1 | One-cycle bus-error pulse |
| cp_reset | output | 1 | Coprocessor reset line from the host |
| host_rd | input | 1 | Host byte read strobe |
| host_wr | input | 1 | Host byte write strobe |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after `host_rd` |
| host_irq | input | 1 | Host interrupt pending, reflected in status bit 4 |

## Verification
Suppose the controller wrongly leaves ST_WAIT. The coprocessor would then see `cp_ready` or `cp_berr` one cycle after a host access that should not have completed the cycle. The status byte would also read back the idle base one read later. A wrong window or region decode shows up one cycle after the request as a wrong bus-error pulse, or in the first status read. A lane-increment or capture error shows up in the first address-byte read. Because idle address reads invert the held value, a missing or doubled toggle is exposed by two reads in a row.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int ADDR_W  = 24;
    localparam int DATA_W  = 16;
    localparam int HOFF_W  = 3;
    localparam int BYTE_W  = 8;
    localparam int NUM_WIN = 10;

    // host register offsets whose position software decodes
    localparam logic [HOFF_W-1:0] OFF_DLO   = 3'd0;
    localparam logic [HOFF_W-1:0] OFF_DHI   = 3'd1;
    localparam logic [HOFF_W-1:0] OFF_ALO   = 3'd2;
    localparam logic [HOFF_W-1:0] OFF_AMID  = 3'd3;
    localparam logic [HOFF_W-1:0] OFF_AHI   = 3'd4;
    localparam logic [HOFF_W-1:0] OFF_STAT  = 3'd7;

    localparam logic [BYTE_W-1:0] STAT_IDLE = 8'hE4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_DONE,
        ST_FAULT,
        ST_DRAIN
    } cyc_state_e;
endpackage

// File: rtl/bridge_window_dec.sv
module bridge_window_dec
    import bridge_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic              fwd
);
    localparam logic [ADDR_W-1:0] WIN_LO [NUM_WIN] = '{
        24'h200000, 24'h420000, 24'h510000, 24'h520000, 24'h538000,
        24'h5F2000, 24'h690000, 24'h6F0000, 24'h730000, 24'h7A0000};
    localparam logic [ADDR_W-1:0] WIN_HI [NUM_WIN] = '{
        24'h2FFFFF, 24'h42FFFF, 24'h51FFFF, 24'h52FFFF, 24'h53FFFF,
        24'h5F3FFF, 24'h69FFFF, 24'h6FFFFF, 24'h73FFFF, 24'h7AFFFF};

    logic [NUM_WIN-1:0] hit;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        assign hit[i] = (addr >= WIN_LO[i]) && (addr <= WIN_HI[i]);
    end

    assign fwd = |hit;
endmodule

// File: rtl/bridge_status_fmt.sv
module bridge_status_fmt
    import bridge_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              pending,
    input  logic              pend_rd,
    input  logic              irq,
    output logic [BYTE_W-1:0] status
);
    logic [BYTE_W-1:0] base;

    always_comb begin
        if (!pending)
            base = STAT_IDLE;
        else if (addr >= 24'h200000 && addr <= 24'h2FFFFF)
            base = 8'h30;
        else if (addr >= 24'h512000 && addr <= 24'h517FFF)
            base = 8'h70;
        else if (addr >= 24'h51FF00 && addr <= 24'h51FFFF)
            base = 8'h50;
        else if (addr >= 24'h538000 && addr <= 24'h53FFFF)
            base = 8'hB0;
        else
            base = 8'hD0;
        status = base | {3'b000, ~irq, 1'b0, pending & pend_rd, 2'b00};
    end
endmodule

// File: rtl/cp_host_bridge.sv
module cp_host_bridge
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cp_req,
    input  logic              cp_we,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [1:0]        cp_lanes,
    input  logic [DATA_W-1:0] cp_wdata,
    output logic [DATA_W-1:0] cp_rdata,
    output logic              cp_ready,
    output logic              cp_berr,
    output logic              cp_reset,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [HOFF_W-1:0] host_addr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              host_irq
);
    cyc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              pend_rd_q;
    logic              rst_bit_q;
    logic [BYTE_W-1:0] rdata_q;
    logic              fwd;
    logic [BYTE_W-1:0] status;
    logic              pending;
    logic              capture;
    logic              wr_ack;
    logic              wr_abort;
    logic [ADDR_W-1:0] addr_flip;

    bridge_window_dec u_win (
        .addr (cp_addr),
        .fwd  (fwd)
    );

    bridge_status_fmt u_stat (
        .addr    (addr_q),
        .pending (pending),
        .pend_rd (pend_rd_q),
        .irq     (host_irq),
        .status  (status)
    );

    assign pending   = (state_q == ST_WAIT);
    assign capture   = (state_q == ST_IDLE) && cp_req && fwd;
    assign wr_ack    = host_wr && (host_addr == OFF_STAT);
    assign wr_abort  = host_wr && (host_addr == OFF_AMID);
    assign addr_flip = ~addr_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cp_req) state_d = fwd ? ST_WAIT : ST_FAULT;
            ST_WAIT: begin
                if (wr_abort)
                    state_d = ST_FAULT;
                else if (wr_ack && !rst_bit_q)
                    state_d = ST_DONE;
            end
            ST_DONE:  state_d = ST_DRAIN;
            ST_FAULT: state_d = ST_DRAIN;
            ST_DRAIN: if (!cp_req) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured cycle, data word and host read path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            data_q    <= '0;
            pend_rd_q <= 1'b0;
            rst_bit_q <= 1'b0;
            rdata_q   <= '0;
        end else begin
            if (host_wr) begin
                unique case (host_addr)
                    OFF_DLO: data_q[7:0]  <= host_wdata;
                    OFF_DHI: data_q[15:8] <= host_wdata;
                    OFF_ALO: rst_bit_q    <= host_wdata[0];
                    default: ;
                endcase
            end
            if (host_rd) begin
                unique case (host_addr)
                    OFF_DLO:  rdata_q <= data_q[7:0];
                    OFF_DHI:  rdata_q <= data_q[15:8];
                    OFF_ALO, OFF_AMID, OFF_AHI: begin
                        if (pending) begin
                            rdata_q <= addr_q[8*(host_addr-OFF_ALO) +: 8];
                        end else begin
                            rdata_q <= addr_flip[8*(host_addr-OFF_ALO) +: 8];
                            addr_q  <= addr_flip;
                        end
                    end
                    OFF_STAT: rdata_q <= status;
                    default:  rdata_q <= '0;
                endcase
            end
            if (capture) begin
                addr_q    <= (cp_lanes == 2'b01) ? cp_addr + 1'b1 : cp_addr;
                pend_rd_q <= ~cp_we;
                if (cp_we) data_q <= cp_wdata;
            end
        end
    end

    // outputs
    always_comb begin
        cp_ready   = (state_q == ST_DONE);
        cp_berr    = (state_q == ST_FAULT);
        cp_rdata   = data_q;
        cp_reset   = rst_bit_q;
        host_rdata = rdata_q;
    end
endmodule

// File: rtl/cp_host_bridge_chk.sv
module cp_host_bridge_chk
    import bridge_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [HOFF_W-1:0] host_addr,
    input logic              host_wbit0,
    input logic              cp_ready,
    input logic              cp_berr,
    input logic              cp_reset
);
    // R5
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_ready |=> !cp_ready);

    // R5
    ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_ready |-> $past(host_wr && host_addr == OFF_STAT));

    // R7
    berr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_berr |=> !cp_berr);

    // R2
    no_dual_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cp_ready && cp_berr));

    // R6
    ack_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFF_STAT && cp_reset) |=> !cp_ready);

    // R8
    reset_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFF_ALO) |=> (cp_reset == $past(host_wbit0)));
endmodule

bind cp_host_bridge cp_host_bridge_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wbit0 (host_wdata[0]),
    .cp_ready   (cp_ready),
    .cp_berr    (cp_berr),
    .cp_reset   (cp_reset)
);

// File: tb/cp_host_bridge_tb.sv
module cp_host_bridge_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    // {addr, lanes, we, wdata}
    localparam logic [42:0] VEC [NVEC] = '{
        {24'h200000, 2'b11, 1'b0, 16'h0000},
        {24'h2FFFFE, 2'b01, 1'b1, 16'h1234},
        {24'h300000, 2'b11, 1'b0, 16'h0000},
        {24'h420010, 2'b11, 1'b1, 16'hBEEF},
        {24'h512000, 2'b10, 1'b0, 16'h0000},
        {24'h51FF00, 2'b11, 1'b0, 16'h0000},
        {24'h538000, 2'b11, 1'b1, 16'h55AA},
        {24'h537FFE, 2'b11, 1'b0, 16'h0000},
        {24'h5F2000, 2'b11, 1'b0, 16'h0000},
        {24'h5F4000, 2'b11, 1'b1, 16'h0F0F},
        {24'h7A1234, 2'b01, 1'b1, 16'hC3C3},
        {24'h6F0000, 2'b11, 1'b0, 16'h0000},
        {24'h690002, 2'b11, 1'b1, 16'h7E81},
        {24'h730100, 2'b10, 1'b0, 16'h0000},
        {24'h520000, 2'b11, 1'b0, 16'h0000},
        {24'h41FFFE, 2'b11, 1'b1, 16'h2222}};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_req = 1'b0, cp_we = 1'b0;
    logic [23:0] cp_addr = '0;
    logic [1:0]  cp_lanes = '0;
    logic [15:0] cp_wdata = '0;
    logic [15:0] cp_rdata;
    logic        cp_ready, cp_berr, cp_reset;
    logic        host_rd = 1'b0, host_wr = 1'b0, host_irq = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cp_host_bridge u_dut (.*);

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [2:0] off, input logic [7:0] d);
        host_wr = 1'b1; host_addr = off; host_wdata = d;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [2:0] off, output logic [7:0] d);
        host_rd = 1'b1; host_addr = off;
        tick();
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    function automatic bit m_fwd(input logic [23:0] a);
        return (a >= 24'h200000 && a <= 24'h2FFFFF) || (a[23:16] == 8'h42) ||
               (a[23:16] == 8'h51) || (a[23:16] == 8'h52) ||
               (a >= 24'h538000 && a <= 24'h53FFFF) ||
               (a >= 24'h5F2000 && a <= 24'h5F3FFF) || (a[23:16] == 8'h69) ||
               (a[23:16] == 8'h6F) || (a[23:16] == 8'h73) || (a[23:16] == 8'h7A);
    endfunction

    function automatic logic [7:0] m_region(input logic [23:0] a);
        if (a >= 24'h200000 && a <= 24'h2FFFFF) return 8'h30;
        if (a >= 24'h512000 && a <= 24'h517FFF) return 8'h70;
        if (a >= 24'h51FF00 && a <= 24'h51FFFF) return 8'h50;
        if (a >= 24'h538000 && a <= 24'h53FFFF) return 8'hB0;
        return 8'hD0;
    endfunction

    task automatic start_req(input logic [23:0] a, input logic [1:0] ln,
                             input logic we, input logic [15:0] wd);
        cp_addr = a; cp_lanes = ln; cp_we = we; cp_wdata = wd; cp_req = 1'b1;
        tick();
    endtask

    task automatic end_req();
        cp_req = 1'b0;
        tick(); tick();
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] b;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R11: reset state
        check(!cp_ready && !cp_berr && !cp_reset, "R11", {cp_ready, cp_berr, cp_reset}, 0);
        hread(3'd7, b);
        check(b == 8'hF4, "R11 R9 idle status", b, 8'hF4);
        hread(3'd2, b);
        check(b == 8'hFF, "R10 R11 first idle addr read", b, 8'hFF);
        hread(3'd3, b);
        check(b == 8'h00, "R10 second idle addr read", b, 8'h00);
        host_irq = 1'b1;
        hread(3'd7, b);
        check(b == 8'hE4, "R9 irq pending", b, 8'hE4);
        host_irq = 1'b0;

        // table of accesses
        for (int i = 0; i < NVEC; i++) begin
            logic [23:0] a  = VEC[i][42:19];
            logic [1:0]  ln = VEC[i][18:17];
            logic        we = VEC[i][16];
            logic [15:0] wd = VEC[i][15:0];
            logic [23:0] la = (ln == 2'b01) ? a + 24'd1 : a;
            logic [15:0] rd = a[15:0] ^ 16'hA5C3;
            logic [7:0]  es = m_region(la) | (we ? 8'h10 : 8'h14);
            start_req(a, ln, we, wd);
            if (!m_fwd(a)) begin
                check(cp_berr && !cp_ready, "R1 reject", {cp_berr, cp_ready}, 2);
                end_req();
                check(!cp_berr, "R7 berr one cycle", cp_berr, 0);
            end else begin
                check(!cp_berr && !cp_ready, "R1 R2 stall", {cp_berr, cp_ready}, 0);
                tick();
                check(!cp_berr && !cp_ready, "R2 still stalled", {cp_berr, cp_ready}, 0);
                hread(3'd7, b);
                check(b == es, "R9 status", b, es);
                hread(3'd2, b);
                check(b == la[7:0], "R3 addr low", b, la[7:0]);
                hread(3'd3, b);
                check(b == la[15:8], "R3 addr mid", b, la[15:8]);
                hread(3'd4, b);
                check(b == la[23:16], "R3 addr high", b, la[23:16]);
                if (we) begin
                    hread(3'd0, b);
                    check(b == wd[7:0], "R4 wdata low", b, wd[7:0]);
                    hread(3'd1, b);
                    check(b == wd[15:8], "R4 wdata high", b, wd[15:8]);
                end else begin
                    hwrite(3'd0, rd[7:0]);
                    hwrite(3'd1, rd[15:8]);
                end
                check(!cp_ready, "R2 no ready before ack", cp_ready, 0);
                hwrite(3'd7, 8'h00);
                check(cp_ready && !cp_berr, "R5 ack", {cp_ready, cp_berr}, 2);
                if (!we) check(cp_rdata == rd, "R4 read data", cp_rdata, rd);
                cp_req = 1'b0;
                tick();
                check(!cp_ready, "R5 ready one cycle", cp_ready, 0);
                tick();
            end
        end

        // R8 and R6: ack ignored under reset bit
        hwrite(3'd2, 8'h01);
        check(cp_reset, "R8 reset bit set", cp_reset, 1);
        start_req(24'h200000, 2'b11, 1'b0, 16'h0);
        hwrite(3'd7, 8'h00);
        check(!cp_ready, "R6 ack ignored", cp_ready, 0);
        tick();
        check(!cp_ready && !cp_berr, "R6 still stalled", {cp_ready, cp_berr}, 0);
        hread(3'd7, b);
        check(b == 8'h34, "R6 still pending status", b, 8'h34);
        hwrite(3'd2, 8'hFE);
        check(!cp_reset, "R8 reset bit clear", cp_reset, 0);
        hwrite(3'd7, 8'h00);
        check(cp_ready, "R6 ack after release", cp_ready, 1);
        end_req();

        // R7: forced bus error on pending cycle
        start_req(24'h420000, 2'b11, 1'b0, 16'h0);
        hwrite(3'd3, 8'h00);
        check(cp_berr && !cp_ready, "R7 forced berr", {cp_berr, cp_ready}, 2);
        end_req();
        hread(3'd7, b);
        check(b == 8'hF4, "R7 idle after abort", b, 8'hF4);
        hwrite(3'd3, 8'h00);
        check(!cp_berr, "R7 idle abort ignored", cp_berr, 0);
        tick();
        check(!cp_berr && !cp_ready, "R7 idle abort ignored", {cp_berr, cp_ready}, 0);

        // R10: toggling on idle reads (held 0x420000)
        hread(3'd2, b);
        check(b == 8'hFF, "R10 inverted low", b, 8'hFF);
        hread(3'd4, b);
        check(b == 8'h42, "R10 toggled back high", b, 8'h42);

        // R11: reset during pending cycle
        start_req(24'h730000, 2'b11, 1'b1, 16'h9999);
        cp_req = 1'b0;
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        hread(3'd7, b);
        check(b == 8'hF4, "R11 pending cleared", b, 8'hF4);
        hread(3'd3, b);
        check(b == 8'hFF, "R11 address cleared", b, 8'hFF);
        hread(3'd0, b);
        check(b == 8'h00, "R11 data cleared", b, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule